// File: doc/BRIEF.md
# Flash Program and Erase Controller

This block sequences erase and program operations on an on-chip flash array, modelled here as a behavioural register array. Software selects an operation through a small control register, loads a target address for page erase, and starts the operation with a go bit. A program cycle starts when the bus writes one 16-bit half-word while programming is selected. While an operation runs, the controller reports busy, holds off the bus with a stall, and ignores register writes. When the operation finishes it raises a sticky completion flag. A program of a half-word that is not erased raises a sticky program-error flag, and an operation aimed at protected storage raises a sticky protection-error flag.

Permission comes from two neighbouring units. A key sequencer drives `unlocked`, which gates control-register writes. A protection unit drives a mask with one bit per protection domain, where each domain is a fixed group of pages. Page size, page count, domain size and the busy times for erase and program are parameters.

Top module: `fpec_ctrl`

## Requirements
- R1: After reset `busy`, all three status flags and `ctl_mode` are 0, and every half-word of the array reads 0xFFFF (the erased value).
- R2: A control write with page-select (bit 1) and go (bit 3) set, and no other operation bit set, erases the page that contains the address register (page index = address bits [AW-1:log2(PAGE_BYTES)]). Only that page reads 0xFFFF afterwards. `busy` stays high for exactly ERASE_CYC cycles.
- R3: A control write with mass-select (bit 2) and go (bit 3) set erases every page, after ERASE_CYC busy cycles.
- R4: With program-select (bit 0) held in the control register, a bus write of size code 1 (half-word) to an erased half-word stores the data after PROG_CYC busy cycles. The completion flag (status bit 0) is set in the cycle that `busy` falls.
- R5: A half-word program whose target does not read 0xFFFF and whose data is not 0x0000 is not performed. It sets the program-error flag (status bit 1) and does not raise `busy`.
- R6: A half-word program with data 0x0000 is performed even when the target is not erased.
- R7: With program-select set, a bus write of size code 0 (byte) or 2 (word) asserts `bus_err` in the same cycle and changes no array contents.
- R8: While `busy` is 1, writes to the control, address and status registers are ignored, and any bus request sees `bus_stall` = 1.
- R9: A go with no operation bit set, or with more than one of bits 0 to 2 set, starts nothing and leaves `busy` at 0.
- R10: A `prot_map` bit d = 1 protects pages d*DOM_PAGES to d*DOM_PAGES+DOM_PAGES-1. A page erase or program aimed there is not performed, sets the protection-error flag (status bit 2) and leaves `busy` at 0. A mass erase is refused in the same way when any domain is protected.
- R11: The status flags are sticky. Writing 1 to a flag's bit position in a status write clears that flag, and a 0 leaves it unchanged.
- R12: Control-register writes are ignored while `unlocked` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unlocked | input | 1 | Control writes permitted (from key sequencer) |
| prot_map | input | NUM_DOM | Per-domain write protection, 1 = protected |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | bit0 program, bit1 page erase, bit2 mass erase, bit3 go |
| adr_we | input | 1 | Address register write strobe |
| adr_wdata | input | AW | Byte address for page erase |
| sts_we | input | 1 | Status write strobe (write 1 to clear) |
| sts_wdata | input | 3 | bit0 done, bit1 program error, bit2 protection error |
| bus_req | input | 1 | Flash bus access request |
| bus_we | input | 1 | Access is a write |
| bus_size | input | 2 | 0 byte, 1 half-word, 2 word |
| bus_addr | input | AW | Byte address of access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of half-word at bus_addr |
| bus_stall | output | 1 | Access held off while busy |
| bus_err | output | 1 | Program write of wrong size |
| busy | output | 1 | Operation in progress |
| sts_done | output | 1 | Sticky completion flag |
| sts_pgerr | output | 1 | Sticky program error flag |
| sts_wperr | output | 1 | Sticky protection error flag |
| ctl_mode | output | 3 | Stored operation-select bits |

## Verification
The programming path is exercised with data written to an erased cell, nonzero data written over a programmed cell, and zero data written over a programmed cell. These three cases separate the erased-check refusal from the zero-data exception. Erases are run page-wise and array-wide, with a programmed word left in a neighbouring page, so that an erase of the wrong extent shows up on readback. Register, address and status writes and bus reads are issued in the middle of a busy window, and the results are compared after it ends. Protection is tested with one domain masked: a program and a page erase inside that domain and a mass erase must be refused, while a program in the open domain still lands.

// File: rtl/fpec_pkg.sv
package fpec_pkg;
   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_PAGE = 2'd1,
      OP_MASS = 2'd2,
      OP_PROG = 2'd3
   } fpec_op_e;

   localparam int CB_PROG = 0;
   localparam int CB_PAGE = 1;
   localparam int CB_MASS = 2;
   localparam int CB_GO   = 3;

   localparam int SB_DONE  = 0;
   localparam int SB_PGERR = 1;
   localparam int SB_WPERR = 2;
   localparam int NUM_FLAGS = 3;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;

   localparam logic [15:0] ERASED_HW = 16'hFFFF;
endpackage

// File: rtl/fpec_regs.sv
module fpec_regs
   import fpec_pkg::*;
#(
   parameter int AW = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 busy,
   input  logic                 unlocked,
   input  logic                 ctl_we,
   input  logic [3:0]           ctl_wdata,
   input  logic                 adr_we,
   input  logic [AW-1:0]        adr_wdata,
   input  logic                 sts_we,
   input  logic [NUM_FLAGS-1:0] sts_wdata,
   input  logic [NUM_FLAGS-1:0] flag_set,
   output logic [2:0]           cr_q,
   output logic [AW-1:0]        ar_q,
   output logic [NUM_FLAGS-1:0] flags_q,
   output logic                 ctl_go
);
   logic ctl_ok;
   assign ctl_ok = ctl_we && unlocked && !busy;
   assign ctl_go = ctl_ok && ctl_wdata[CB_GO];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cr_q <= '0;
         ar_q <= '0;
      end else begin
         if (ctl_ok) cr_q <= ctl_wdata[2:0];
         if (adr_we && !busy) ar_q <= adr_wdata;
      end
   end

   for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flags_q[f] <= 1'b0;
         else if (flag_set[f]) flags_q[f] <= 1'b1;
         else if (sts_we && !busy && sts_wdata[f]) flags_q[f] <= 1'b0;
      end
   end

   assert_ctl_frozen_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cr_q) && $stable(ar_q));
endmodule

// File: rtl/fpec_seq.sv
module fpec_seq
   import fpec_pkg::*;
#(
   parameter int ERASE_CYC = 20,
   parameter int PROG_CYC  = 6,
   parameter int PIDX_W    = 2,
   parameter int OFF_W     = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  fpec_op_e          launch_op,
   input  logic [PIDX_W-1:0] launch_page,
   input  logic [OFF_W-1:0]  launch_off,
   input  logic [15:0]       launch_data,
   output logic              busy,
   output logic              fin,
   output fpec_op_e          op_q,
   output logic [PIDX_W-1:0] page_q,
   output logic [OFF_W-1:0]  off_q,
   output logic [15:0]       data_q
);
   localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
   localparam int CW      = $clog2(MAX_CYC + 1);

   if (ERASE_CYC < 1 || PROG_CYC < 1) begin : g_bad_cyc
      $error("busy durations must be at least one cycle");
   end

   logic [CW-1:0] cnt;
   assign fin = busy && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cnt    <= '0;
         op_q   <= OP_NONE;
         page_q <= '0;
         off_q  <= '0;
         data_q <= '0;
      end else if (busy) begin
         if (cnt == '0) begin
            busy <= 1'b0;
            op_q <= OP_NONE;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end else if (launch) begin
         busy   <= 1'b1;
         op_q   <= launch_op;
         page_q <= launch_page;
         off_q  <= launch_off;
         data_q <= launch_data;
         cnt    <= (launch_op == OP_PROG) ? CW'(PROG_CYC - 1) : CW'(ERASE_CYC - 1);
      end
   end

   assert_busy_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt != '0) |=> busy);
endmodule

// File: rtl/fpec_array.sv
module fpec_array
   import fpec_pkg::*;
#(
   parameter int PAGE_BYTES = 1024,
   parameter int NUM_PAGES  = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [$clog2(NUM_PAGES)-1:0] rd_page,
   input  logic [$clog2(PAGE_BYTES)-2:0] rd_off,
   output logic [15:0]                  rd_data,
   input  logic                         wr_en,
   input  logic                         erase_page_en,
   input  logic                         erase_all_en,
   input  logic [$clog2(NUM_PAGES)-1:0] tgt_page,
   input  logic [$clog2(PAGE_BYTES)-2:0] tgt_off,
   input  logic [15:0]                  wr_data
);
   localparam int HWP    = PAGE_BYTES / 2;
   localparam int PIDX_W = $clog2(NUM_PAGES);

   if (PAGE_BYTES != 1024 && PAGE_BYTES != 2048) begin : g_bad_page
      $error("page size must be 1024 or 2048 bytes");
   end
   if (NUM_PAGES < 2 || (1 << PIDX_W) != NUM_PAGES) begin : g_bad_count
      $error("page count must be a power of two, at least 2");
   end

   logic [15:0] bank_rd [NUM_PAGES];

   for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
      logic [15:0] cells [HWP];
      logic        hit;
      assign hit = (tgt_page == PIDX_W'(p));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < HWP; i++) cells[i] <= ERASED_HW;
         end else if (erase_all_en || (erase_page_en && hit)) begin
            for (int i = 0; i < HWP; i++) cells[i] <= ERASED_HW;
         end else if (wr_en && hit) begin
            cells[tgt_off] <= wr_data;
         end
      end
      assign bank_rd[p] = cells[rd_off];
   end

   assign rd_data = bank_rd[rd_page];

   assert_one_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_en, erase_page_en, erase_all_en}));
endmodule

// File: rtl/fpec_ctrl.sv
module fpec_ctrl
   import fpec_pkg::*;
#(
   parameter int PAGE_BYTES = 1024,
   parameter int NUM_PAGES  = 4,
   parameter int DOM_PAGES  = 2,
   parameter int ERASE_CYC  = 20,
   parameter int PROG_CYC   = 6,
   localparam int AW        = $clog2(PAGE_BYTES * NUM_PAGES),
   localparam int NUM_DOM   = NUM_PAGES / DOM_PAGES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               unlocked,
   input  logic [NUM_DOM-1:0] prot_map,
   input  logic               ctl_we,
   input  logic [3:0]         ctl_wdata,
   input  logic               adr_we,
   input  logic [AW-1:0]      adr_wdata,
   input  logic               sts_we,
   input  logic [2:0]         sts_wdata,
   input  logic               bus_req,
   input  logic               bus_we,
   input  logic [1:0]         bus_size,
   input  logic [AW-1:0]      bus_addr,
   input  logic [15:0]        bus_wdata,
   output logic [15:0]        bus_rdata,
   output logic               bus_stall,
   output logic               bus_err,
   output logic               busy,
   output logic               sts_done,
   output logic               sts_pgerr,
   output logic               sts_wperr,
   output logic [2:0]         ctl_mode
);
   localparam int PG_LSB = $clog2(PAGE_BYTES);
   localparam int PIDX_W = $clog2(NUM_PAGES);
   localparam int OFF_W  = PG_LSB - 1;
   localparam int DOM_SH = $clog2(DOM_PAGES);

   if (DOM_PAGES < 1 || (1 << DOM_SH) != DOM_PAGES || NUM_DOM * DOM_PAGES != NUM_PAGES) begin : g_bad_dom
      $error("domain size must be a power of two dividing the page count");
   end

   function automatic logic page_protected(input logic [PIDX_W-1:0] pg, input logic [NUM_DOM-1:0] map);
      logic r;
      r = 1'b0;
      for (int d = 0; d < NUM_DOM; d++)
         if (d == (int'(pg) >> DOM_SH)) r = map[d];
      return r;
   endfunction

   logic [2:0]        cr_q;
   logic [AW-1:0]     ar_q;
   logic [2:0]        flags_q;
   logic [2:0]        flag_set;
   logic              ctl_go, fin, launch;
   fpec_op_e          launch_op, op_q;
   logic [PIDX_W-1:0] page_q, ar_page, bus_page, launch_page;
   logic [OFF_W-1:0]  off_q, bus_off;
   logic [15:0]       data_q, rd_data;
   logic              erase_req, erase_prot, hw_wr, prog_prot, prog_bad, prog_go;

   assign ar_page  = ar_q[AW-1:PG_LSB];
   assign bus_page = bus_addr[AW-1:PG_LSB];
   assign bus_off  = bus_addr[PG_LSB-1:1];

   fpec_regs #(.AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .busy(busy), .unlocked(unlocked),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .adr_we(adr_we), .adr_wdata(adr_wdata),
      .sts_we(sts_we), .sts_wdata(sts_wdata),
      .flag_set(flag_set), .cr_q(cr_q), .ar_q(ar_q),
      .flags_q(flags_q), .ctl_go(ctl_go)
   );

   always_comb begin
      erase_req  = ctl_go && $onehot(ctl_wdata[2:0]) && !ctl_wdata[CB_PROG];
      erase_prot = ctl_wdata[CB_MASS] ? (|prot_map) : page_protected(ar_page, prot_map);
      bus_err    = bus_req && bus_we && !busy && cr_q[CB_PROG] && (bus_size != SZ_HALF);
      hw_wr      = bus_req && bus_we && !busy && cr_q[CB_PROG] && (bus_size == SZ_HALF);
      prog_prot  = hw_wr && page_protected(bus_page, prot_map);
      prog_bad   = hw_wr && !prog_prot && (rd_data != ERASED_HW) && (bus_wdata != 16'h0000);
      prog_go    = hw_wr && !prog_prot && !prog_bad;
      launch     = (erase_req && !erase_prot) || prog_go;
      launch_op  = prog_go ? OP_PROG : (ctl_wdata[CB_MASS] ? OP_MASS : OP_PAGE);
      launch_page = prog_go ? bus_page : ar_page;
      flag_set[SB_DONE]  = fin;
      flag_set[SB_PGERR] = prog_bad;
      flag_set[SB_WPERR] = (erase_req && erase_prot) || prog_prot;
   end

   fpec_seq #(
      .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .PIDX_W(PIDX_W), .OFF_W(OFF_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .launch(launch), .launch_op(launch_op),
      .launch_page(launch_page), .launch_off(bus_off), .launch_data(bus_wdata),
      .busy(busy), .fin(fin), .op_q(op_q), .page_q(page_q),
      .off_q(off_q), .data_q(data_q)
   );

   fpec_array #(.PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES)) u_array (
      .clk(clk), .rst_n(rst_n),
      .rd_page(bus_page), .rd_off(bus_off), .rd_data(rd_data),
      .wr_en(fin && op_q == OP_PROG),
      .erase_page_en(fin && op_q == OP_PAGE),
      .erase_all_en(fin && op_q == OP_MASS),
      .tgt_page(page_q), .tgt_off(off_q), .wr_data(data_q)
   );

   assign bus_rdata = rd_data;
   assign bus_stall = bus_req && busy;
   assign sts_done  = flags_q[SB_DONE];
   assign sts_pgerr = flags_q[SB_PGERR];
   assign sts_wperr = flags_q[SB_WPERR];
   assign ctl_mode  = cr_q;

   assert_done_on_finish_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> sts_done);
   assert_pgerr_no_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      prog_bad |=> !busy && sts_pgerr);
   assert_wperr_no_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flag_set[SB_WPERR] |=> !busy && sts_wperr);
   assert_stall_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stall |-> !bus_err);
endmodule

// File: tb/fpec_ctrl_tb.sv
module fpec_ctrl_tb;
   localparam int ERC = 20;
   localparam int PRC = 6;
   localparam int AW  = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        unlocked = 1'b1;
   logic [1:0]  prot_map = '0;
   logic        ctl_we = 1'b0, adr_we = 1'b0, sts_we = 1'b0;
   logic [3:0]  ctl_wdata = '0;
   logic [AW-1:0] adr_wdata = '0, bus_addr = '0;
   logic [2:0]  sts_wdata = '0;
   logic        bus_req = 1'b0, bus_we = 1'b0;
   logic [1:0]  bus_size = 2'd1;
   logic [15:0] bus_wdata = '0, bus_rdata;
   logic        bus_stall, bus_err, busy, sts_done, sts_pgerr, sts_wperr;
   logic [2:0]  ctl_mode;

   int checks = 0;
   int errors = 0;
   bit ended = 0;

   int    exp_q[$];
   string tag_q[$];
   event  rd_ev;

   always #4 clk = ~clk;

   fpec_ctrl #(.ERASE_CYC(ERC), .PROG_CYC(PRC)) u_dut (
      .clk(clk), .rst_n(rst_n), .unlocked(unlocked), .prot_map(prot_map),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .adr_we(adr_we), .adr_wdata(adr_wdata),
      .sts_we(sts_we), .sts_wdata(sts_wdata), .bus_req(bus_req), .bus_we(bus_we),
      .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_stall(bus_stall), .bus_err(bus_err), .busy(busy),
      .sts_done(sts_done), .sts_pgerr(sts_pgerr), .sts_wperr(sts_wperr), .ctl_mode(ctl_mode)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // scoreboard monitor: compares every read against the queued expectation
   initial forever begin
      @(rd_ev);
      if (exp_q.size() == 0) check("scoreboard underflow", 1, 0);
      else check(tag_q.pop_front(), int'(bus_rdata), exp_q.pop_front());
   end

   task automatic rd_check(input logic [AW-1:0] a, input int exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      bus_req = 1; bus_we = 0; bus_addr = a;
      #1;
      -> rd_ev;
      @(negedge clk);
      bus_req = 0;
   endtask

   task automatic ctl_wr(input logic [3:0] d);
      @(negedge clk); ctl_we = 1; ctl_wdata = d;
      @(negedge clk); ctl_we = 0;
   endtask

   task automatic adr_wr(input logic [AW-1:0] a);
      @(negedge clk); adr_we = 1; adr_wdata = a;
      @(negedge clk); adr_we = 0;
   endtask

   task automatic sts_wr(input logic [2:0] d);
      @(negedge clk); sts_we = 1; sts_wdata = d;
      @(negedge clk); sts_we = 0;
   endtask

   task automatic bus_wr(input logic [AW-1:0] a, input logic [15:0] d,
                         input logic [1:0] sz, output logic err);
      @(negedge clk);
      bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_size = sz;
      #1 err = bus_err;
      @(negedge clk);
      bus_req = 0; bus_we = 0; bus_size = 2'd1;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic prog_hw(input logic [AW-1:0] a, input logic [15:0] d);
      logic e;
      int n;
      bus_wr(a, d, 2'd1, e);
      wait_idle(n);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic e;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1 busy", busy, 0);
      check("R1 flags", {sts_wperr, sts_pgerr, sts_done}, 0);
      check("R1 ctl_mode", ctl_mode, 0);
      rd_check(12'h000, 16'hFFFF, "R1 erased low");
      rd_check(12'hFFE, 16'hFFFF, "R1 erased high");

      // R4 program erased cell
      ctl_wr(4'b0001);
      check("R4 mode", ctl_mode, 1);
      bus_wr(12'h004, 16'h1234, 2'd1, e);
      check("R4 no bus_err", e, 0);
      wait_idle(n);
      check("R4 busy cycles", n, PRC);
      check("R4 done", sts_done, 1);
      rd_check(12'h004, 16'h1234, "R4 data");

      // R11 clear done
      sts_wr(3'b001);
      check("R11 done cleared", sts_done, 0);

      // R5 overwrite refused
      bus_wr(12'h004, 16'h5678, 2'd1, e);
      check("R5 no busy", busy, 0);
      check("R5 pgerr", sts_pgerr, 1);
      rd_check(12'h004, 16'h1234, "R5 data kept");

      // R6 zero always written
      bus_wr(12'h004, 16'h0000, 2'd1, e);
      check("R6 busy", busy, 1);
      wait_idle(n);
      rd_check(12'h004, 16'h0000, "R6 zero data");

      // R7 wrong sizes
      bus_wr(12'h006, 16'hAAAA, 2'd0, e);
      check("R7 byte err", e, 1);
      bus_wr(12'h006, 16'hAAAA, 2'd2, e);
      check("R7 word err", e, 1);
      check("R7 no busy", busy, 0);
      rd_check(12'h006, 16'hFFFF, "R7 untouched");

      // R11 partial clear: done only
      sts_wr(3'b001);
      check("R11 partial done", sts_done, 0);
      check("R11 partial pgerr", sts_pgerr, 1);

      // R2 page erase of page 0, page 1 keeps data
      prog_hw(12'h404, 16'hBEEF);
      adr_wr(12'h010);
      ctl_wr(4'b1010);
      wait_idle(n);
      check("R2 busy cycles", n, ERC);
      rd_check(12'h004, 16'hFFFF, "R2 page0 erased");
      rd_check(12'h404, 16'hBEEF, "R2 page1 kept");

      // R8 writes ignored while busy
      ctl_wr(4'b0001);
      prog_hw(12'h008, 16'h1111);
      adr_wr(12'h400);
      ctl_wr(4'b1010);
      ctl_wr(4'b0101);
      adr_wr(12'h008);
      sts_wr(3'b010);
      @(negedge clk);
      bus_req = 1; bus_we = 0; bus_addr = 12'h000;
      #1 check("R8 stall", bus_stall, 1);
      @(negedge clk); bus_req = 0;
      wait_idle(n);
      check("R8 mode kept", ctl_mode, 3'b010);
      check("R8 pgerr kept", sts_pgerr, 1);
      rd_check(12'h404, 16'hFFFF, "R8 page1 erased");
      rd_check(12'h008, 16'h1111, "R8 addr write ignored");

      // R9 bad go encodings
      ctl_wr(4'b1000);
      check("R9 go alone", busy, 0);
      ctl_wr(4'b1110);
      check("R9 two ops", busy, 0);
      rd_check(12'h008, 16'h1111, "R9 no erase");

      // R12 locked
      unlocked = 0;
      ctl_wr(4'b0001);
      check("R12 mode kept", ctl_mode, 3'b110);
      unlocked = 1;

      // R10 protection of domain 1 (pages 2,3)
      sts_wr(3'b111);
      prot_map = 2'b10;
      ctl_wr(4'b0001);
      bus_wr(12'h800, 16'h2222, 2'd1, e);
      check("R10 prog no busy", busy, 0);
      check("R10 prog wperr", sts_wperr, 1);
      rd_check(12'h800, 16'hFFFF, "R10 prog refused");
      prog_hw(12'h00A, 16'h3333);
      rd_check(12'h00A, 16'h3333, "R10 open domain");
      sts_wr(3'b100);
      adr_wr(12'hC00);
      ctl_wr(4'b1010);
      check("R10 page erase no busy", busy, 0);
      check("R10 page erase wperr", sts_wperr, 1);
      sts_wr(3'b100);
      ctl_wr(4'b1100);
      check("R10 mass no busy", busy, 0);
      check("R10 mass wperr", sts_wperr, 1);
      rd_check(12'h00A, 16'h3333, "R10 mass refused");

      // R3 mass erase
      prot_map = 2'b00;
      ctl_wr(4'b0001);
      prog_hw(12'hC02, 16'h4444);
      rd_check(12'hC02, 16'h4444, "R3 pre data");
      ctl_wr(4'b1100);
      wait_idle(n);
      check("R3 busy cycles", n, ERC);
      rd_check(12'h008, 16'hFFFF, "R3 page0 a");
      rd_check(12'h00A, 16'hFFFF, "R3 page0 b");
      rd_check(12'hC02, 16'hFFFF, "R3 page3");

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule